// File: doc/BRIEF.md
# Pulse-Driven Up/Down Counter with Preset and Cascade Flags

This block is a small binary counter stepped by two separate pulse lines: one line moves the count up and the other moves it down. A single system clock samples both lines. A rising edge on one line, seen while the other line sits high, moves the count by one. A clear input forces the count to zero. A load input copies a data word into the count and ignores any pulses while it is held, so the block can divide by N through presetting.

Two active-low flags let instances be chained with no glue logic. The wrap flag toward zero goes low while the count is zero and the down line is low. The wrap flag toward the maximum goes low while the count is all ones and the up line is low. Each flag feeds the same-direction pulse input of the next stage, so the next stage steps when the pulse line of this stage returns high. The pulse lines pass through a synchronizer before edge detection, so they may be asynchronous to the system clock. Clear and load are sampled as synchronous inputs.

Top module: `updn_pulse_counter`

## Requirements
- R1: The count is WIDTH bits (default 4) in natural binary. Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R2: A rising edge of `cnt_up_i` while `cnt_dn_i` is high adds one to the count. The new value appears after the third rising clock edge that follows the input change (two synchronizer flops plus the count register).
- R3: A rising edge of `cnt_dn_i` while `cnt_up_i` is high subtracts one from the count, with the same latency as R2.
- R4: The count holds when both pulse inputs rise in the same sampled cycle, or when one input rises while the other is low.
- R5: `clr_i` high at a clock edge sets the count to 0 at that edge, whatever `load_n_i` and the pulse inputs are doing.
- R6: `load_n_i` low, with `clr_i` low, at a clock edge copies `data_i` into the count at that edge. Pulse edges during the load have no effect on the count, and none is applied after the load ends.
- R7: `borrow_n_o` is 0 exactly when the count is 0 and the synchronized `cnt_dn_i` is low. Otherwise it is 1.
- R8: `carry_n_o` is 0 exactly when the count is all ones and the synchronized `cnt_up_i` is low. Otherwise it is 1.
- R9: Three instances chained as described (`carry_n_o` to the next `cnt_up_i`, `borrow_n_o` to the next `cnt_dn_i`) behave as one 12-bit up/down counter.
- R10: A synchronous `rst` sets the count to 0 and puts the synchronizers in the idle-high state. Both flags are then 1, and pulse inputs that are high after reset produce no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_up_i | input | 1 | Up pulse line, idles high; a rising edge counts up |
| cnt_dn_i | input | 1 | Down pulse line, idles high; a rising edge counts down |
| clr_i | input | 1 | Clear, active high, highest priority |
| load_n_i | input | 1 | Preset enable, active low |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| borrow_n_o | output | 1 | Low while the count is zero and the down line is low |
| carry_n_o | output | 1 | Low while the count is all ones and the up line is low |

## Verification
Single up pulses and single down pulses establish direction and latency. The wrap cases at all ones and at zero show whether the flags ripple into the next stage of a three-stage chain. Pulses with both lines low at once, and up edges while the down line is low, separate the hold rule from a plain edge count. Flags are read at zero, at one, at all ones and at all ones minus one. A preset held during pulses, and a clear applied during a load, separate the priority order. A long pseudo-random sequence of up and down pulses across the chain is compared with a 12-bit reference count.

// File: rtl/updn_pkg.sv
package updn_pkg;

    // Action selected for the count register in one clock cycle.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_INC   = 3'd1,
        ACT_DEC   = 3'd2,
        ACT_LOAD  = 3'd3,
        ACT_CLEAR = 3'd4
    } updn_act_e;

    localparam int NUM_PULSE_CH = 2;
    localparam int CH_UP        = 0;
    localparam int CH_DN        = 1;

endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    // The chain resets to the idle-high level, so a line that is already
    // high after reset never produces a false edge.
    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/updn_step_ctrl.sv
module updn_step_ctrl
    import updn_pkg::*;
(
    input  logic      clr_i,
    input  logic      load_n_i,
    input  logic      up_rise_i,
    input  logic      dn_rise_i,
    input  logic      up_lvl_i,
    input  logic      dn_lvl_i,
    output updn_act_e act_o
);

    logic step_up;
    logic step_dn;

    // A step needs exactly one edge while the opposite line rests high.
    assign step_up = up_rise_i & ~dn_rise_i & dn_lvl_i;
    assign step_dn = dn_rise_i & ~up_rise_i & up_lvl_i;

    always_comb begin
        if (clr_i) begin
            act_o = ACT_CLEAR;
        end else if (!load_n_i) begin
            act_o = ACT_LOAD;
        end else if (step_up) begin
            act_o = ACT_INC;
        end else if (step_dn) begin
            act_o = ACT_DEC;
        end else begin
            act_o = ACT_HOLD;
        end
    end

endmodule

// File: rtl/updn_count_reg.sv
module updn_count_reg
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  updn_act_e        act_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act_i)
            ACT_CLEAR: st_d.cnt = '0;
            ACT_LOAD:  st_d.cnt = data_i;
            ACT_INC:   st_d.cnt = st_q.cnt + ONE;
            ACT_DEC:   st_d.cnt = st_q.cnt - ONE;
            default:   st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/updn_flag_gen.sv
module updn_flag_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count_i,
    input  logic             up_lvl_i,
    input  logic             dn_lvl_i,
    output logic             borrow_n_o,
    output logic             carry_n_o
);

    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic at_zero;
    logic at_max;

    assign at_zero    = (count_i == '0);
    assign at_max     = (count_i == CNT_MAX);
    assign borrow_n_o = ~(at_zero & ~dn_lvl_i);
    assign carry_n_o  = ~(at_max & ~up_lvl_i);

endmodule

// File: rtl/updn_pulse_counter.sv
module updn_pulse_counter
    import updn_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_up_i,
    input  logic             cnt_dn_i,
    input  logic             clr_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             borrow_n_o,
    output logic             carry_n_o
);

    logic [NUM_PULSE_CH-1:0] pulse_raw;
    logic [NUM_PULSE_CH-1:0] pulse_lvl;
    logic [NUM_PULSE_CH-1:0] pulse_rise;
    updn_act_e               act;

    assign pulse_raw[CH_UP] = cnt_up_i;
    assign pulse_raw[CH_DN] = cnt_dn_i;

    for (genvar ch = 0; ch < NUM_PULSE_CH; ch++) begin : g_sync
        updn_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) sync_i (
            .clk     (clk),
            .rst     (rst),
            .async_i (pulse_raw[ch]),
            .level_o (pulse_lvl[ch]),
            .rise_o  (pulse_rise[ch])
        );
    end

    updn_step_ctrl ctrl_i (
        .clr_i     (clr_i),
        .load_n_i  (load_n_i),
        .up_rise_i (pulse_rise[CH_UP]),
        .dn_rise_i (pulse_rise[CH_DN]),
        .up_lvl_i  (pulse_lvl[CH_UP]),
        .dn_lvl_i  (pulse_lvl[CH_DN]),
        .act_o     (act)
    );

    updn_count_reg #(
        .WIDTH (WIDTH)
    ) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .act_i   (act),
        .data_i  (data_i),
        .count_o (count_o)
    );

    updn_flag_gen #(
        .WIDTH (WIDTH)
    ) flag_i (
        .count_i    (count_o),
        .up_lvl_i   (pulse_lvl[CH_UP]),
        .dn_lvl_i   (pulse_lvl[CH_DN]),
        .borrow_n_o (borrow_n_o),
        .carry_n_o  (carry_n_o)
    );

endmodule

// File: rtl/updn_pulse_counter_chk.sv
module updn_pulse_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             load_n_i,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] count_o,
    input logic             borrow_n_o,
    input logic             carry_n_o
);

    localparam logic [WIDTH-1:0] STEP  = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOPV  = '1;

    // R1: without clear or load the count moves by at most one, wrapping
    p_single_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && load_n_i) |=> (count_o == $past(count_o) ||
                                  count_o == $past(count_o) + STEP ||
                                  count_o == $past(count_o) - STEP));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (count_o == '0));

    p_load_copy_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !load_n_i) |=> (count_o == $past(data_i)));

    p_borrow_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !borrow_n_o |-> (count_o == '0));

    p_carry_at_top_r8: assert property (@(posedge clk) disable iff (rst)
        !carry_n_o |-> (count_o == TOPV));

    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (count_o == '0 && borrow_n_o && carry_n_o));

endmodule

bind updn_pulse_counter updn_pulse_counter_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr_i),
    .load_n_i   (load_n_i),
    .data_i     (data_i),
    .count_o    (count_o),
    .borrow_n_o (borrow_n_o),
    .carry_n_o  (carry_n_o)
);

// File: tb/updn_pulse_counter_tb_top.sv
module updn_pulse_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up0 = 1'b1;
    logic        dn0 = 1'b1;
    logic        clr = 1'b0;
    logic        load_n = 1'b1;
    logic [11:0] data12 = '0;
    logic [11:0] ref_cnt = '0;
    logic [3:0]  cnt [3];
    logic [2:0]  bo_n;
    logic [2:0]  cy_n;
    int          checks = 0;
    int          errors = 0;
    logic [7:0]  lfsr = 8'hA5;

    always #4 clk = ~clk;

    updn_pulse_counter dut_i (
        .clk(clk), .rst(rst), .cnt_up_i(up0), .cnt_dn_i(dn0), .clr_i(clr),
        .load_n_i(load_n), .data_i(data12[3:0]), .count_o(cnt[0]),
        .borrow_n_o(bo_n[0]), .carry_n_o(cy_n[0]));

    updn_pulse_counter stage1_i (
        .clk(clk), .rst(rst), .cnt_up_i(cy_n[0]), .cnt_dn_i(bo_n[0]), .clr_i(clr),
        .load_n_i(load_n), .data_i(data12[7:4]), .count_o(cnt[1]),
        .borrow_n_o(bo_n[1]), .carry_n_o(cy_n[1]));

    updn_pulse_counter stage2_i (
        .clk(clk), .rst(rst), .cnt_up_i(cy_n[1]), .cnt_dn_i(bo_n[1]), .clr_i(clr),
        .load_n_i(load_n), .data_i(data12[11:8]), .count_o(cnt[2]),
        .borrow_n_o(bo_n[2]), .carry_n_o(cy_n[2]));

    function automatic logic [11:0] full_count();
        return {cnt[2], cnt[1], cnt[0]};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_up();
        up0 = 1'b0; tick(6); up0 = 1'b1; tick(14);
        ref_cnt = ref_cnt + 12'd1;
    endtask

    task automatic pulse_dn();
        dn0 = 1'b0; tick(6); dn0 = 1'b1; tick(14);
        ref_cnt = ref_cnt - 12'd1;
    endtask

    task automatic do_load(input logic [11:0] v);
        data12 = v; load_n = 1'b0; tick(2); load_n = 1'b1; tick(3);
        ref_cnt = v;
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(3); rst = 1'b0; tick(8);
        chk("R10 count after reset", full_count(), 12'h000);
        chk("R10 borrow after reset", {11'd0, bo_n[0]}, 12'h001);
        chk("R10 carry after reset", {11'd0, cy_n[0]}, 12'h001);
        ref_cnt = '0;
    endtask

    task automatic t_up_down();
        pulse_up(); pulse_up(); pulse_up();
        chk("R2 three up pulses", full_count(), 12'h003);
        pulse_dn();
        chk("R3 one down pulse", full_count(), 12'h002);
        // latency: change at a falling edge, visible after the third rising edge
        up0 = 1'b0; tick(5); up0 = 1'b1;
        tick(2);
        chk("R2 not yet counted after two edges", {8'd0, cnt[0]}, 12'h002);
        tick(1);
        chk("R2 counted after third edge", {8'd0, cnt[0]}, 12'h003);
        tick(12);
    endtask

    task automatic t_wrap();
        do_load(12'h00F);
        pulse_up();
        chk("R1 low stage wraps up to 0", {8'd0, cnt[0]}, 12'h000);
        chk("R9 carry ripples into stage 1", full_count(), ref_cnt);
        do_load(12'h000);
        pulse_dn();
        chk("R1 low stage wraps down to F", {8'd0, cnt[0]}, 12'h00F);
        chk("R9 borrow ripples through all stages", full_count(), 12'hFFF);
    endtask

    task automatic t_hold();
        do_load(12'h044);
        up0 = 1'b0; dn0 = 1'b0; tick(6);
        up0 = 1'b1; dn0 = 1'b1; tick(14);
        chk("R4 simultaneous rise holds", full_count(), 12'h044);
        dn0 = 1'b0; tick(6);
        up0 = 1'b0; tick(6); up0 = 1'b1; tick(14);
        chk("R4 up rise while down low holds", full_count(), 12'h044);
        dn0 = 1'b1; tick(14);
        chk("R3 down rise while up high counts", full_count(), 12'h043);
        ref_cnt = 12'h043;
    endtask

    task automatic t_flags();
        do_load(12'h000);
        dn0 = 1'b0; tick(4);
        chk("R7 borrow low at zero with down low", {11'd0, bo_n[0]}, 12'h000);
        chk("R8 carry high at zero", {11'd0, cy_n[0]}, 12'h001);
        dn0 = 1'b1; tick(14);
        chk("R7 borrow released, chain at FFF", full_count(), 12'hFFF);
        do_load(12'h001);
        dn0 = 1'b0; tick(4);
        chk("R7 borrow high at one", {11'd0, bo_n[0]}, 12'h001);
        dn0 = 1'b1; tick(14);
        do_load(12'h000);
        chk("R7 borrow high at zero with down high", {11'd0, bo_n[0]}, 12'h001);
        do_load(12'h00F);
        up0 = 1'b0; tick(4);
        chk("R8 carry low at max with up low", {11'd0, cy_n[0]}, 12'h000);
        up0 = 1'b1; tick(14);
        chk("R8 carry release advances chain", full_count(), 12'h010);
        do_load(12'h00E);
        up0 = 1'b0; tick(4);
        chk("R8 carry high below max", {11'd0, cy_n[0]}, 12'h001);
        up0 = 1'b1; tick(14);
        chk("R2 count reaches max", full_count(), 12'h00F);
        chk("R8 carry high at max with up high", {11'd0, cy_n[0]}, 12'h001);
    endtask

    task automatic t_clear();
        do_load(12'h5A3);
        data12 = 12'h7FF; load_n = 1'b0; clr = 1'b1; tick(2);
        chk("R5 clear wins over load", full_count(), 12'h000);
        clr = 1'b0; load_n = 1'b1; tick(3);
        do_load(12'h123);
        up0 = 1'b0; tick(3); clr = 1'b1; tick(1); clr = 1'b0; tick(3);
        up0 = 1'b1; tick(14);
        chk("R5 clear mid pulse then count", full_count(), 12'h001);
        ref_cnt = 12'h001;
    endtask

    task automatic t_load_pulses();
        data12 = 12'h5A3; load_n = 1'b0; tick(2);
        for (int k = 0; k < 3; k++) begin
            up0 = 1'b0; tick(6); up0 = 1'b1; tick(6);
        end
        dn0 = 1'b0; tick(6); dn0 = 1'b1; tick(6);
        chk("R6 count follows data during pulses", full_count(), 12'h5A3);
        load_n = 1'b1; tick(14);
        chk("R6 no pulse applied after load ends", full_count(), 12'h5A3);
        ref_cnt = 12'h5A3;
    endtask

    task automatic t_cascade();
        do_load(12'hFFD);
        for (int k = 0; k < 48; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (k < 6 || lfsr[0]) pulse_up(); else pulse_dn();
            chk("R9 chain matches 12-bit reference", full_count(), ref_cnt);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(1);
        t_reset();
        t_up_down();
        t_wrap();
        t_hold();
        t_flags();
        t_clear();
        t_load_pulses();
        t_cascade();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule